// File: doc/BRIEF.md
# Dual-ROM Microcode Sequencer

This block steps through microcode held in two separate program ROMs and hands each fetched word to an instruction decoder. One ROM carries the curve-arithmetic routines and the other carries the cipher and MAC routines. Only one ROM is active during a run. The ROM that is not in use is kept quiet: its enable stays low and its address does not move.

A run begins with a start pulse and a command code. The command picks a ROM and an entry address, and the sequencer then fetches one word per cycle from the synchronous ROM. The ROM has one cycle of read latency. A call carries only a short index, and a small computed lookup turns that index into the subroutine's address. The return address lives in a single 11-bit register, so a call can nest to one level only. A halt word ends the run.

The control is a three-state machine:
- IDLE: waits for a start.
- FILL: the first address of a new flow is on the ROM and no data has come back yet.
- EXEC: a valid word is being decoded.

The transitions are:
- start: IDLE to FILL.
- prime: FILL to EXEC.
- advance: EXEC to EXEC, for a sequential word, an ignored call or an unmatched return.
- redirect: EXEC to FILL, for a taken call or return.
- halt: EXEC to IDLE.

Top module: `useq_core`

## Requirements
- R1: After reset, busy_o, done_o, nest_err_o, instr_valid_o, rom_sel_o and both ROM enables are 0, and pc_o is 0.
- R2: A start_i in IDLE moves to FILL. Bit 2 of cmd_i picks the ROM (0 = curve ROM A, 1 = cipher ROM B). pc_o loads 64 × cmd_i[1:0], and busy_o goes high on the next edge. A start_i while busy is ignored.
- R3: The two most significant bits of each ROM word give its class: 00 sequential, 01 call, 10 return, 11 halt. Each sequential word advances pc_o by one on the next edge, with no idle cycle between consecutive sequential fetches.
- R4: A call whose index is the low 4 bits of the word jumps to 1024 + 32 × index in the same ROM. It saves (call address + 1) as the return address. The word fetched behind a taken call or return is discarded, so instr_valid_o is low for one cycle.
- R5: A return with an address held jumps to that address and frees the register. A return with nothing held acts as a sequential word.
- R6: A call while a return address is held raises nest_err_o for one cycle. The call is otherwise ignored: it acts as a sequential word and the held address is kept.
- R7: A halt word clears busy_o and pulses done_o for exactly one cycle, on the same edge.
- R8: The ROM that is not selected, and both ROMs while idle, keep their enable low and their address unchanged.
- R9: instr_valid_o is high in EXEC, and instr_o carries the word being decoded, zero-extended to 16 bits.
- R10: A start_i in the same cycle that a halt word is decoded is dropped. The block ends idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| cmd_i | input | 3 | Command: ROM select and entry slot |
| rom_a_addr_o | output | 11 | Curve ROM address |
| rom_a_en_o | output | 1 | Curve ROM read enable |
| rom_a_data_i | input | 16 | Curve ROM read data |
| rom_b_addr_o | output | 11 | Cipher ROM address |
| rom_b_en_o | output | 1 | Cipher ROM read enable |
| rom_b_data_i | input | 12 | Cipher ROM read data |
| pc_o | output | 11 | Address being fetched |
| rom_sel_o | output | 1 | Active ROM (0 = A, 1 = B) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| nest_err_o | output | 1 | One-cycle pulse on a rejected nested call |
| instr_valid_o | output | 1 | instr_o holds a word to decode |
| instr_o | output | 16 | Word being decoded, zero-extended |

## Verification
Two events can land in the same cycle: a halt being decoded and a new start request. The bench raises start_i on the falling edge just before the halt word reaches decode. It then expects busy_o low and done_o high after that edge, and busy_o still low one cycle later, which shows the start was dropped. A second case is the nested-call check running together with the sequential advance. Here a call arrives while a return address is held, and the bench expects both an error pulse and pc_o stepping by one.

// File: rtl/useq_pkg.sv
package useq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_EXEC = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_SEQ  = 2'b00,
        OP_CALL = 2'b01,
        OP_RET  = 2'b10,
        OP_HALT = 2'b11
    } op_class_e;
endpackage

// File: rtl/useq_lut.sv
module useq_lut #(
    parameter int PC_W         = 11,
    parameter int CMD_W        = 3,
    parameter int IDX_W        = 4,
    parameter int ENTRY_STRIDE = 64,
    parameter int SUB_BASE     = 1024,
    parameter int SUB_STRIDE   = 32
) (
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             entry_rom_o,
    output logic [PC_W-1:0]  entry_pc_o,
    output logic [PC_W-1:0]  sub_pc_o
);
    localparam logic [PC_W-1:0] EStride = PC_W'(ENTRY_STRIDE);
    localparam logic [PC_W-1:0] SBase   = PC_W'(SUB_BASE);
    localparam logic [PC_W-1:0] SStride = PC_W'(SUB_STRIDE);

    always_comb begin
        entry_rom_o = cmd_i[CMD_W-1];
        entry_pc_o  = PC_W'(cmd_i[CMD_W-2:0]) * EStride;
        sub_pc_o    = SBase + PC_W'(idx_i) * SStride;
    end
endmodule

// File: rtl/useq_rom_port.sv
module useq_rom_port #(
    parameter int PC_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] addr_o,
    output logic            en_o
);
    logic [PC_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (active_i)
            hold_q <= pc_i;
    end

    always_comb begin
        addr_o = active_i ? pc_i : hold_q;
        en_o   = active_i;
    end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
#(
    parameter int OPA_W = 16,
    parameter int OPB_W = 12,
    parameter int IDX_W = 4,
    parameter int OUT_W = 16
) (
    input  logic             sel_i,
    input  logic [OPA_W-1:0] a_i,
    input  logic [OPB_W-1:0] b_i,
    output op_class_e        op_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [OUT_W-1:0] word_o
);
    always_comb begin
        if (sel_i) begin
            word_o = OUT_W'(b_i);
            op_o   = op_class_e'(b_i[OPB_W-1 -: 2]);
        end else begin
            word_o = OUT_W'(a_i);
            op_o   = op_class_e'(a_i[OPA_W-1 -: 2]);
        end
        idx_o = word_o[IDX_W-1:0];
    end
endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
#(
    parameter int PC_W         = 11,
    parameter int CMD_W        = 3,
    parameter int IDX_W        = 4,
    parameter int OPA_W        = 16,
    parameter int OPB_W        = 12,
    parameter int ENTRY_STRIDE = 64,
    parameter int SUB_BASE     = 1024,
    parameter int SUB_STRIDE   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CMD_W-1:0]     cmd_i,
    output logic [PC_W-1:0]      rom_a_addr_o,
    output logic                 rom_a_en_o,
    input  logic [OPA_W-1:0]     rom_a_data_i,
    output logic [PC_W-1:0]      rom_b_addr_o,
    output logic                 rom_b_en_o,
    input  logic [OPB_W-1:0]     rom_b_data_i,
    output logic [PC_W-1:0]      pc_o,
    output logic                 rom_sel_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 nest_err_o,
    output logic                 instr_valid_o,
    output logic [((OPA_W > OPB_W) ? OPA_W : OPB_W)-1:0] instr_o
);
    localparam int OUT_W   = (OPA_W > OPB_W) ? OPA_W : OPB_W;
    localparam int N_ROM   = 2;
    localparam logic [PC_W-1:0] PcOne = PC_W'(1);

    seq_state_e      state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic [PC_W-1:0] ret_q, ret_d;
    logic            held_q, held_d;
    logic            sel_q, sel_d;
    logic            done_q, done_d;
    logic            err_q, err_d;

    logic            entry_rom;
    logic [PC_W-1:0] entry_pc;
    logic [PC_W-1:0] sub_pc;
    op_class_e       op;
    logic [IDX_W-1:0] idx;
    logic [OUT_W-1:0] word;
    logic            running;

    useq_lut #(
        .PC_W(PC_W), .CMD_W(CMD_W), .IDX_W(IDX_W),
        .ENTRY_STRIDE(ENTRY_STRIDE), .SUB_BASE(SUB_BASE), .SUB_STRIDE(SUB_STRIDE)
    ) u_lut (
        .cmd_i(cmd_i), .idx_i(idx),
        .entry_rom_o(entry_rom), .entry_pc_o(entry_pc), .sub_pc_o(sub_pc)
    );

    useq_decode #(
        .OPA_W(OPA_W), .OPB_W(OPB_W), .IDX_W(IDX_W), .OUT_W(OUT_W)
    ) u_dec (
        .sel_i(sel_q), .a_i(rom_a_data_i), .b_i(rom_b_data_i),
        .op_o(op), .idx_o(idx), .word_o(word)
    );

    assign running = (state_q != ST_IDLE);

    logic [PC_W-1:0] port_addr [N_ROM];
    logic            port_en   [N_ROM];

    for (genvar g = 0; g < N_ROM; g++) begin : g_port
        useq_rom_port #(.PC_W(PC_W)) u_port (
            .clk(clk), .rst_n(rst_n),
            .active_i(running && (sel_q == 1'(g))),
            .pc_i(pc_q),
            .addr_o(port_addr[g]), .en_o(port_en[g])
        );
    end

    // next-state and register-next logic
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        ret_d   = ret_q;
        held_d  = held_q;
        sel_d   = sel_q;
        done_d  = 1'b0;
        err_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_FILL;
                    pc_d    = entry_pc;
                    sel_d   = entry_rom;
                end
            end
            ST_FILL: begin
                pc_d    = pc_q + PcOne;
                state_d = ST_EXEC;
            end
            ST_EXEC: begin
                unique case (op)
                    OP_SEQ: pc_d = pc_q + PcOne;
                    OP_CALL: begin
                        if (held_q) begin
                            err_d = 1'b1;
                            pc_d  = pc_q + PcOne;
                        end else begin
                            ret_d   = pc_q;
                            held_d  = 1'b1;
                            pc_d    = sub_pc;
                            state_d = ST_FILL;
                        end
                    end
                    OP_RET: begin
                        if (held_q) begin
                            pc_d    = ret_q;
                            held_d  = 1'b0;
                            state_d = ST_FILL;
                        end else begin
                            pc_d = pc_q + PcOne;
                        end
                    end
                    OP_HALT: begin
                        state_d = ST_IDLE;
                        held_d  = 1'b0;
                        done_d  = 1'b1;
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            ret_q   <= '0;
            held_q  <= 1'b0;
            sel_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            ret_q   <= ret_d;
            held_q  <= held_d;
            sel_q   <= sel_d;
            done_q  <= done_d;
            err_q   <= err_d;
        end
    end

    // outputs
    always_comb begin
        pc_o          = pc_q;
        rom_sel_o     = sel_q;
        busy_o        = running;
        done_o        = done_q;
        nest_err_o    = err_q;
        instr_valid_o = (state_q == ST_EXEC);
        instr_o       = word;
        rom_a_addr_o  = port_addr[0];
        rom_a_en_o    = port_en[0];
        rom_b_addr_o  = port_addr[1];
        rom_b_en_o    = port_en[1];
    end
endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk #(
    parameter int PC_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [PC_W-1:0] rom_a_addr_o,
    input logic            rom_a_en_o,
    input logic [PC_W-1:0] rom_b_addr_o,
    input logic            rom_b_en_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            nest_err_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R7
    AST_ONE_ROM_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_a_en_o && rom_b_en_o)); // R8
    AST_A_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_a_en_o && $past(!rom_a_en_o)) |-> $stable(rom_a_addr_o)); // R8
    AST_B_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_b_en_o && $past(!rom_b_en_o)) |-> $stable(rom_b_addr_o)); // R8
    AST_BUSY_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rom_a_en_o || rom_b_en_o)); // R2
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R2
    AST_ERR_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        nest_err_o |-> busy_o); // R6
endmodule

bind useq_core useq_core_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/useq_core_bench.sv
`timescale 1ns/1ps
module useq_core_bench;
    typedef struct packed {
        logic [10:0] pc;
        logic        busy;
        logic        done;
        logic        err;
        logic        valid;
    } exp_t;

    // main trace: cmd 1 -> ROM A entry 64, call idx 2 (1088), nested call, return, halt
    localparam exp_t TRACE [0:11] = '{
        '{11'd64,   1'b1, 1'b0, 1'b0, 1'b0},
        '{11'd65,   1'b1, 1'b0, 1'b0, 1'b1},
        '{11'd66,   1'b1, 1'b0, 1'b0, 1'b1},
        '{11'd1088, 1'b1, 1'b0, 1'b0, 1'b0},
        '{11'd1089, 1'b1, 1'b0, 1'b0, 1'b1},
        '{11'd1090, 1'b1, 1'b0, 1'b0, 1'b1},
        '{11'd1091, 1'b1, 1'b0, 1'b1, 1'b1},
        '{11'd66,   1'b1, 1'b0, 1'b0, 1'b0},
        '{11'd67,   1'b1, 1'b0, 1'b0, 1'b1},
        '{11'd68,   1'b1, 1'b0, 1'b0, 1'b1},
        '{11'd68,   1'b0, 1'b1, 1'b0, 1'b0},
        '{11'd68,   1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [2:0]  cmd_i;
    logic [10:0] rom_a_addr_o, rom_b_addr_o, pc_o;
    logic        rom_a_en_o, rom_b_en_o;
    logic [15:0] rom_a_data_i;
    logic [11:0] rom_b_data_i;
    logic        rom_sel_o, busy_o, done_o, nest_err_o, instr_valid_o;
    logic [15:0] instr_o;

    logic [15:0] mem_a [0:2047];
    logic [11:0] mem_b [0:2047];

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    useq_core u_useq_core (.*);

    always @(posedge clk) begin
        if (rom_a_en_o) rom_a_data_i <= mem_a[rom_a_addr_o];
        if (rom_b_en_o) rom_b_data_i <= mem_b[rom_b_addr_o];
    end

    function automatic logic [15:0] wa(input logic [1:0] op, input logic [3:0] idx);
        return {op, 10'd0, idx};
    endfunction

    function automatic logic [11:0] wb(input logic [1:0] op, input logic [3:0] idx);
        return {op, 6'd0, idx};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mem_a[i] = '0;
            mem_b[i] = '0;
        end
        rom_a_data_i = '0;
        rom_b_data_i = '0;
        mem_a[65]   = wa(2'b01, 4'd2);
        mem_a[67]   = wa(2'b11, 4'd0);
        mem_a[1089] = wa(2'b01, 4'd1);
        mem_a[1090] = wa(2'b10, 4'd0);
        mem_b[65]   = wb(2'b11, 4'd5);
        mem_a[128]  = wa(2'b10, 4'd0);
        mem_a[129]  = wa(2'b11, 4'd0);

        rst_n = 1'b0; start_i = 1'b0; cmd_i = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 err", nest_err_o, 0);
        chk("R1 pc", pc_o, 0);
        chk("R1 enables", {rom_a_en_o, rom_b_en_o}, 0);
        chk("R1 valid", instr_valid_o, 0);

        // table walk: R2 R3 R4 R5 R6 R7
        start_i = 1'b1; cmd_i = 3'd1;
        for (int i = 0; i < 12; i++) begin
            step();
            if (i == 0) start_i = 1'b0;
            chk("R2/R3/R4/R5 pc", pc_o, TRACE[i].pc);
            chk("R2/R7 busy", busy_o, TRACE[i].busy);
            chk("R7 done", done_o, TRACE[i].done);
            chk("R6 nest_err", nest_err_o, TRACE[i].err);
            chk("R4/R9 valid", instr_valid_o, TRACE[i].valid);
            if (i == 2) chk("R9 instr_o call word", instr_o, 32'h4002);
        end

        // R2 R8 R9: ROM B run, start while busy ignored
        start_i = 1'b1; cmd_i = 3'd5;
        step();
        start_i = 1'b1; cmd_i = 3'd2;
        chk("R2 sel B", rom_sel_o, 1);
        chk("R2 entry B", pc_o, 64);
        chk("R8 A gated", rom_a_en_o, 0);
        chk("R8 A addr held", rom_a_addr_o, 68);
        chk("R8 B enabled", rom_b_en_o, 1);
        step();
        start_i = 1'b0;
        chk("R2 start ignored pc", pc_o, 65);
        chk("R2 start ignored sel", rom_sel_o, 1);
        step();
        chk("R3 pc after seq", pc_o, 66);
        chk("R9 valid", instr_valid_o, 1);
        chk("R9 zero-extended word", instr_o, 32'h0C05);
        step();
        chk("R7 done B", done_o, 1);
        chk("R7 busy B", busy_o, 0);
        chk("R8 idle enables", {rom_a_en_o, rom_b_en_o}, 0);
        chk("R8 B addr held", rom_b_addr_o, 66);

        // R5 unmatched return, R10 start colliding with halt
        start_i = 1'b1; cmd_i = 3'd2;
        step();
        start_i = 1'b0;
        chk("R2 entry A 128", pc_o, 128);
        chk("R2 sel A", rom_sel_o, 0);
        step();
        chk("R5 pc", pc_o, 129);
        step();
        chk("R5 unmatched ret acts seq", pc_o, 130);
        start_i = 1'b1; cmd_i = 3'd0;
        step();
        start_i = 1'b0;
        chk("R10 busy low", busy_o, 0);
        chk("R10 done", done_o, 1);
        chk("R10 pc", pc_o, 130);
        step();
        chk("R10 start dropped", busy_o, 0);
        chk("R10 enables off", {rom_a_en_o, rom_b_en_o}, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule